// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches write transfers on a parallel flash-style bus and recognises the multi-write command handshakes that such a memory accepts. Most commands begin with two fixed unlock writes, and the writes that follow select program, chip erase, sector erase, identifier (autoselect) or bypass entry. A few commands take a single write: return to read, query mode entry, suspend and resume. When a sequence completes, the block raises a one-cycle command pulse with a command code. It also holds the program address and data, the sector address or the bank address that the command carried.

The block also tracks the current read mode: plain array read, identifier read, query read or unlock-bypass. In unlock-bypass a program or a chip erase needs only two writes. An upstream bus interface resolves the chip-enable and write-enable strobes into a single-cycle write pulse, with the address and data stable while the pulse is high. The flash array model supplies a busy flag, which decides whether a suspend is accepted.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, cmdValid is 0, cmdKind is 0 (none), mode is 0 (read) and suspended is 0.
- R2: A write is one cycle with wrStb high. A write that completes a command raises cmdValid for the following cycle only, with cmdKind coded as: 1 program, 2 chip erase, 3 sector erase, 4 autoselect, 5 query, 6 reset, 7 suspend, 8 resume, 9 bypass entry, 10 bypass exit. cmdKind holds its value after the pulse, and intermediate writes give no pulse.
- R3: The four writes AA@555, 55@2AA, A0@555 and then PD@PA decode as program. opAddr becomes PA and opData becomes the full-width PD.
- R4: AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 decode as chip erase.
- R5: The same first five writes as chip erase, followed by 30 at any address SA, decode as sector erase with opAddr = SA.
- R6: A single write of F0 at any address decodes as reset and sets mode to 0. A single write of 98 at address 055 decodes as query and sets mode to 2.
- R7: AA@555, 55@2AA, then 90 at an address whose low bits are 555 decodes as autoselect. It sets mode to 1 and captures that full address (bank) in opAddr.
- R8: Command matching compares only address bits 11:0 and data bits 7:0. Higher bits are ignored, while a difference inside those bits breaks the match.
- R9: A write that does not fit the next expected step of a partial sequence returns the decoder to idle with no command. That write is not taken as the start of a new sequence.
- R10: AA@555, 55@2AA, 20@555 decodes as bypass entry and sets mode to 3. In mode 3, A0 at any address followed by PD@PA decodes as program, and 80 followed by 10 decodes as chip erase.
- R11: In mode 3, the writes 90 and then 00 decode as bypass exit and set mode to 0. In mode 3, any other write (such as F0, or 90 followed by something other than 00) gives no command and leaves mode at 3.
- R12: A single write of B0 decodes as suspend and sets suspended to 1, capturing its address, only while arrayBusy is 1 and suspended is 0. Otherwise it gives no command.
- R13: A single write of 30 from idle decodes as resume and clears suspended, capturing its address, only while suspended is 1. Otherwise it gives no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStb | input | 1 | One-cycle bus write pulse |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| arrayBusy | input | 1 | Array is running a program or erase |
| cmdValid | output | 1 | One-cycle decoded-command pulse |
| cmdKind | output | 4 | Code of the last decoded command |
| opAddr | output | ADDR_W | Program, sector or bank address of the last command that carries one |
| opData | output | DATA_W | Program data of the last program command |
| mode | output | 2 | 0 read, 1 autoselect, 2 query, 3 bypass |
| suspended | output | 1 | An operation is suspended |

## Verification
The assertions check four things on every cycle. A command pulse always follows a write. Suspended rises only after a busy cycle and falls only after a resume write. Bypass mode is entered only from the end of an unlock pair and left only from the exit step. A program pulse always carries the address and data of the write just before it. Only the directed scenarios can show that each full sequence yields the right code and captured fields. The same goes for ignoring upper address and data bits, for aborted sequences leaving no trace and not restarting, and for bypass mode rejecting standard single-write commands.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    CMD_NONE         = 4'd0,
    CMD_PROGRAM      = 4'd1,
    CMD_CHIP_ERASE   = 4'd2,
    CMD_SECTOR_ERASE = 4'd3,
    CMD_AUTOSEL      = 4'd4,
    CMD_QUERY        = 4'd5,
    CMD_RESET        = 4'd6,
    CMD_SUSPEND      = 4'd7,
    CMD_RESUME       = 4'd8,
    CMD_BYP_ENTER    = 4'd9,
    CMD_BYP_EXIT     = 4'd10
  } cmdKindE;

  typedef enum logic [1:0] {
    MODE_READ    = 2'd0,
    MODE_AUTOSEL = 2'd1,
    MODE_QUERY   = 2'd2,
    MODE_BYPASS  = 2'd3
  } modeE;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ER1, S_ER2, S_ER3,
    S_BPROG, S_BERASE, S_BEXIT
  } seqStateE;

  // comparator results for the current write
  typedef struct packed {
    logic a555, a2aa, a055;
    logic dAA, d55, dA0, d80, d90, d20, d10, d30, dF0, d98, dB0, d00;
  } matchT;

  // strobes from control to datapath
  typedef struct packed {
    logic    emit;
    cmdKindE kind;
    logic    capAddr;
    logic    capData;
  } ctrlStrobeT;

endpackage

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 32,
  parameter int KEY_ADDR_BITS = 12,
  parameter int KEY_DATA_BITS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStrobeT        strb,
  output matchT             match,
  output logic              cmdValid,
  output cmdKindE           cmdKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData
);

  localparam int NUM_CODES = 12;
  localparam logic [KEY_ADDR_BITS-1:0] K555 = KEY_ADDR_BITS'(12'h555);
  localparam logic [KEY_ADDR_BITS-1:0] K2AA = KEY_ADDR_BITS'(12'h2AA);
  localparam logic [KEY_ADDR_BITS-1:0] K055 = KEY_ADDR_BITS'(12'h055);
  localparam logic [NUM_CODES*8-1:0] CODE_LIST =
    {8'hAA, 8'h55, 8'hA0, 8'h80, 8'h90, 8'h20,
     8'h10, 8'h30, 8'hF0, 8'h98, 8'hB0, 8'h00};

  logic [KEY_ADDR_BITS-1:0] keyAddr;
  logic [KEY_DATA_BITS-1:0] keyData;
  logic [NUM_CODES-1:0]     codeHit;

  assign keyAddr = wrAddr[KEY_ADDR_BITS-1:0];
  assign keyData = wrData[KEY_DATA_BITS-1:0];

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
    assign codeHit[NUM_CODES-1-i] =
      (keyData == KEY_DATA_BITS'(CODE_LIST[(NUM_CODES-1-i)*8 +: 8]));
  end

  assign match.a555 = (keyAddr == K555);
  assign match.a2aa = (keyAddr == K2AA);
  assign match.a055 = (keyAddr == K055);
  assign {match.dAA, match.d55, match.dA0, match.d80, match.d90, match.d20,
          match.d10, match.d30, match.dF0, match.d98, match.dB0, match.d00} = codeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdKind  <= CMD_NONE;
      opAddr   <= '0;
      opData   <= '0;
    end else begin
      cmdValid <= strb.emit;
      if (strb.emit)    cmdKind <= strb.kind;
      if (strb.capAddr) opAddr  <= wrAddr;
      if (strb.capData) opData  <= wrData;
    end
  end

  // R3: a program pulse reports the write that completed it
  a_r3_program_capture: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == CMD_PROGRAM) |-> (opAddr == $past(wrAddr) && opData == $past(wrData)));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStb,
  input  logic       arrayBusy,
  input  matchT      match,
  output ctrlStrobeT strb,
  output modeE       mode,
  output logic       suspended
);

  seqStateE state, nxtState;
  modeE     nxtMode;
  logic     nxtSusp;

  always_comb begin
    nxtState     = state;
    nxtMode      = mode;
    nxtSusp      = suspended;
    strb.emit    = 1'b0;
    strb.kind    = CMD_NONE;
    strb.capAddr = 1'b0;
    strb.capData = 1'b0;
    if (wrStb) begin
      nxtState = S_IDLE;  // any mismatch aborts
      case (state)
        S_IDLE: begin
          if (match.dB0) begin
            if (arrayBusy && !suspended) begin
              strb.emit = 1'b1; strb.kind = CMD_SUSPEND; strb.capAddr = 1'b1;
              nxtSusp = 1'b1;
            end
          end else if (match.d30) begin
            if (suspended) begin
              strb.emit = 1'b1; strb.kind = CMD_RESUME; strb.capAddr = 1'b1;
              nxtSusp = 1'b0;
            end
          end else if (mode == MODE_BYPASS) begin
            if (match.dA0)      nxtState = S_BPROG;
            else if (match.d80) nxtState = S_BERASE;
            else if (match.d90) nxtState = S_BEXIT;
          end else if (match.dF0) begin
            strb.emit = 1'b1; strb.kind = CMD_RESET; nxtMode = MODE_READ;
          end else if (match.d98 && match.a055) begin
            strb.emit = 1'b1; strb.kind = CMD_QUERY; nxtMode = MODE_QUERY;
          end else if (match.dAA && match.a555) begin
            nxtState = S_UNL1;
          end
        end
        S_UNL1: if (match.d55 && match.a2aa) nxtState = S_UNL2;
        S_UNL2: if (match.a555) begin
          if (match.dA0)      nxtState = S_PROG;
          else if (match.d80) nxtState = S_ER1;
          else if (match.d90) begin
            strb.emit = 1'b1; strb.kind = CMD_AUTOSEL; strb.capAddr = 1'b1;
            nxtMode = MODE_AUTOSEL;
          end else if (match.d20) begin
            strb.emit = 1'b1; strb.kind = CMD_BYP_ENTER; nxtMode = MODE_BYPASS;
          end
        end
        S_PROG, S_BPROG: begin
          strb.emit = 1'b1; strb.kind = CMD_PROGRAM;
          strb.capAddr = 1'b1; strb.capData = 1'b1;
        end
        S_ER1: if (match.dAA && match.a555) nxtState = S_ER2;
        S_ER2: if (match.d55 && match.a2aa) nxtState = S_ER3;
        S_ER3: begin
          if (match.d10 && match.a555) begin
            strb.emit = 1'b1; strb.kind = CMD_CHIP_ERASE;
          end else if (match.d30) begin
            strb.emit = 1'b1; strb.kind = CMD_SECTOR_ERASE; strb.capAddr = 1'b1;
          end
        end
        S_BERASE: if (match.d10) begin
          strb.emit = 1'b1; strb.kind = CMD_CHIP_ERASE;
        end
        S_BEXIT: if (match.d00) begin
          strb.emit = 1'b1; strb.kind = CMD_BYP_EXIT; nxtMode = MODE_READ;
        end
        default: nxtState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      mode      <= MODE_READ;
      suspended <= 1'b0;
    end else begin
      state     <= nxtState;
      mode      <= nxtMode;
      suspended <= nxtSusp;
    end
  end

  // R12: suspension only starts after a busy cycle
  a_r12_suspend_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspended) |-> $past(arrayBusy && wrStb));

  // R13: suspension only ends through a resume write
  a_r13_resume_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(suspended) |-> $past(wrStb && match.d30));

  // R10: bypass entered only from the end of the unlock pair
  a_r10_bypass_entry: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BYPASS && $past(mode != MODE_BYPASS)) |-> $past(state == S_UNL2));

  // R11: bypass left only through the exit step
  a_r11_bypass_exit: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_BYPASS && $past(mode == MODE_BYPASS)) |-> $past(state == S_BEXIT && wrStb));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 32,
  parameter int KEY_ADDR_BITS = 12,
  parameter int KEY_DATA_BITS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              arrayBusy,
  output logic              cmdValid,
  output logic [3:0]        cmdKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [1:0]        mode,
  output logic              suspended
);

  matchT      match;
  ctrlStrobeT strb;
  cmdKindE    kindQ;
  modeE       modeQ;

  flash_cmd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrStb     (wrStb),
    .arrayBusy (arrayBusy),
    .match     (match),
    .strb      (strb),
    .mode      (modeQ),
    .suspended (suspended)
  );

  flash_cmd_datapath #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .KEY_ADDR_BITS (KEY_ADDR_BITS),
    .KEY_DATA_BITS (KEY_DATA_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strb     (strb),
    .match    (match),
    .cmdValid (cmdValid),
    .cmdKind  (kindQ),
    .opAddr   (opAddr),
    .opData   (opData)
  );

  assign cmdKind = kindQ;
  assign mode    = modeQ;

  // R2: a command pulse is always the result of a write one cycle earlier
  a_r2_pulse_after_write: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(wrStb));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [18:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        arrayBusy = 1'b0;
  logic        cmdValid;
  logic [3:0]  cmdKind;
  logic [18:0] opAddr;
  logic [31:0] opData;
  logic [1:0]  mode;
  logic        suspended;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .arrayBusy(arrayBusy), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .opAddr(opAddr), .opData(opData), .mode(mode), .suspended(suspended)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one write; returns at the negedge after the capturing posedge
  task automatic wr(input logic [18:0] a, input logic [31:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic expectCmd(input string req, input logic [3:0] kind);
    chk(cmdValid === 1'b1, req, "cmdValid", {31'd0, cmdValid}, 32'd1);
    chk(cmdKind === kind, req, "cmdKind", {28'd0, cmdKind}, {28'd0, kind});
  endtask

  task automatic expectNone(input string req);
    chk(cmdValid === 1'b0, req, "no cmdValid", {31'd0, cmdValid}, 32'd0);
  endtask

  task automatic unlock();
    wr(19'h00555, 32'hAA);
    wr(19'h002AA, 32'h55);
  endtask

  task automatic testReset();
    chk(cmdValid === 1'b0, "R1", "cmdValid", {31'd0, cmdValid}, 32'd0);
    chk(cmdKind === 4'd0, "R1", "cmdKind", {28'd0, cmdKind}, 32'd0);
    chk(mode === 2'd0, "R1", "mode", {30'd0, mode}, 32'd0);
    chk(suspended === 1'b0, "R1", "suspended", {31'd0, suspended}, 32'd0);
  endtask

  task automatic testProgram();
    wr(19'h00555, 32'hAA); expectNone("R2");
    wr(19'h002AA, 32'h55); expectNone("R2");
    wr(19'h00555, 32'hA0); expectNone("R2");
    wr(19'h01234, 32'hDEADBEEF);
    expectCmd("R3", 4'd1);
    chk(opAddr === 19'h01234, "R3", "opAddr", {13'd0, opAddr}, 32'h01234);
    chk(opData === 32'hDEADBEEF, "R3", "opData", opData, 32'hDEADBEEF);
    @(negedge clk);
    chk(cmdValid === 1'b0, "R2", "pulse length", {31'd0, cmdValid}, 32'd0);
    chk(cmdKind === 4'd1, "R2", "kind held", {28'd0, cmdKind}, 32'd1);
  endtask

  task automatic testChipErase();
    unlock(); wr(19'h00555, 32'h80); unlock();
    expectNone("R4");
    wr(19'h00555, 32'h10);
    expectCmd("R4", 4'd2);
  endtask

  task automatic testSectorErase();
    unlock(); wr(19'h00555, 32'h80); unlock();
    wr(19'h7F800, 32'h30);
    expectCmd("R5", 4'd3);
    chk(opAddr === 19'h7F800, "R5", "sector addr", {13'd0, opAddr}, 32'h7F800);
  endtask

  task automatic testSingles();
    wr(19'h00055, 32'h98);
    expectCmd("R6", 4'd5);
    chk(mode === 2'd2, "R6", "query mode", {30'd0, mode}, 32'd2);
    wr(19'h3FFFF, 32'hF0);
    expectCmd("R6", 4'd6);
    chk(mode === 2'd0, "R6", "read mode", {30'd0, mode}, 32'd0);
  endtask

  task automatic testAutoselect();
    unlock();
    wr(19'h60555, 32'h90);
    expectCmd("R7", 4'd4);
    chk(mode === 2'd1, "R7", "autoselect mode", {30'd0, mode}, 32'd1);
    chk(opAddr === 19'h60555, "R7", "bank addr", {13'd0, opAddr}, 32'h60555);
    wr(19'h00000, 32'hF0);
    chk(mode === 2'd0, "R7", "back to read", {30'd0, mode}, 32'd0);
  endtask

  task automatic testUpperBits();
    wr(19'h7F555, 32'hFFFFFFAA);
    wr(19'h4A2AA, 32'h12345655);
    wr(19'h10555, 32'hABCDEFA0);
    wr(19'h00042, 32'h00000077);
    expectCmd("R8", 4'd1);
    chk(opData === 32'h00000077, "R8", "opData", opData, 32'h77);
    // bit 11 set on the first unlock breaks the sequence
    wr(19'h00D55, 32'hAA);
    wr(19'h002AA, 32'h55);
    wr(19'h00555, 32'hA0);
    wr(19'h00050, 32'h00000011);
    expectNone("R8");
    chk(opData === 32'h00000077, "R8", "opData unchanged", opData, 32'h77);
  endtask

  task automatic testAbort();
    unlock(); wr(19'h00555, 32'h77);
    expectNone("R9");
    wr(19'h00555, 32'h10);  // would finish nothing from idle
    expectNone("R9");
    unlock(); wr(19'h00555, 32'h80); wr(19'h00555, 32'hAA);
    wr(19'h002AA, 32'h12);  // wrong data in step five
    expectNone("R9");
    wr(19'h00555, 32'h10);
    expectNone("R9");
    // mismatching AA@555 is not a restart
    unlock(); wr(19'h00555, 32'hAA); wr(19'h002AA, 32'h55);
    wr(19'h00555, 32'hA0);
    expectNone("R9");
    unlock(); wr(19'h00555, 32'hA0); wr(19'h00300, 32'h5A5A);
    expectCmd("R9", 4'd1);
  endtask

  task automatic testBypass();
    unlock(); wr(19'h00555, 32'h20);
    expectCmd("R10", 4'd9);
    chk(mode === 2'd3, "R10", "bypass mode", {30'd0, mode}, 32'd3);
    wr(19'h00000, 32'hA0);
    expectNone("R10");
    wr(19'h05678, 32'hCAFEF00D);
    expectCmd("R10", 4'd1);
    chk(opData === 32'hCAFEF00D, "R10", "opData", opData, 32'hCAFEF00D);
    wr(19'h00123, 32'h80); wr(19'h00456, 32'h10);
    expectCmd("R10", 4'd2);
    wr(19'h00000, 32'hF0);
    expectNone("R11");
    chk(mode === 2'd3, "R11", "F0 ignored", {30'd0, mode}, 32'd3);
    wr(19'h00000, 32'h90); wr(19'h00000, 32'h55);
    expectNone("R11");
    chk(mode === 2'd3, "R11", "bad exit", {30'd0, mode}, 32'd3);
    wr(19'h00000, 32'h90); wr(19'h00000, 32'h00);
    expectCmd("R11", 4'd10);
    chk(mode === 2'd0, "R11", "exit mode", {30'd0, mode}, 32'd0);
  endtask

  task automatic testSuspend();
    arrayBusy = 1'b0;
    wr(19'h40000, 32'hB0);
    expectNone("R12");
    chk(suspended === 1'b0, "R12", "not busy", {31'd0, suspended}, 32'd0);
    wr(19'h40000, 32'h30);
    expectNone("R13");
    chk(suspended === 1'b0, "R13", "nothing to resume", {31'd0, suspended}, 32'd0);
    arrayBusy = 1'b1;
    wr(19'h40000, 32'hB0);
    expectCmd("R12", 4'd7);
    chk(suspended === 1'b1, "R12", "suspended", {31'd0, suspended}, 32'd1);
    chk(opAddr === 19'h40000, "R12", "bank addr", {13'd0, opAddr}, 32'h40000);
    wr(19'h40000, 32'hB0);
    expectNone("R12");
    wr(19'h20000, 32'h30);
    expectCmd("R13", 4'd8);
    chk(suspended === 1'b0, "R13", "resumed", {31'd0, suspended}, 32'd0);
    chk(opAddr === 19'h20000, "R13", "bank addr", {13'd0, opAddr}, 32'h20000);
    wr(19'h20000, 32'h30);
    expectNone("R13");
    arrayBusy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testProgram();
    testChipErase();
    testSectorErase();
    testSingles();
    testAutoselect();
    testUpperBits();
    testAbort();
    testBypass();
    testSuspend();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule